// File: doc/BRIEF.md
# Raster Timing Generator for a Parallel RGB Panel

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, and flags the start of every frame to software. A pair of nested position counters (pixel within line, line within frame) steps once per cycle in which `pix_ce` is high. The counters sweep a line laid out as sync pulse, back porch, active pixels, front porch, and a frame laid out the same way in lines. The sizes of these segments come from a small register set. Most fields hold the length minus one, but the vertical back porch field holds the plain length.

Software brings the output up in three stages: pixel clock, then sync, then display. It shuts the output down in the opposite order. It sets and clears each stage by writing ones to a set register or a clear register, and it follows progress in a status register. The pixel clock stage takes effect on the next cycle. The sync and display stages switch only where one frame ends and the next begins, so a panel never sees a partial frame. A start-of-frame event is latched as pending and gated by a mask bit to drive the interrupt line. Reading the pending register clears it.

Top module: `lcd_timing_gen`

## Requirements
- R1: After synchronous reset the status register reads 0, `lcd_hsync`, `lcd_vsync`, `lcd_de` and `sof_irq` are low, and the interrupt mask is closed.
- R2: A write to address 0x0 sets each stage request whose data bit is one, and a write to 0x1 clears each stage request whose data bit is one. The bits are: bit 0 pixel clock, bit 1 sync, bit 2 display. Address 0x2 reads the stage status in the same bit positions. The pixel clock status bit follows its request on the next clock edge. Read data is registered and is valid on the cycle after `bus_rd`.
- R3: The sync and display status bits change only on the edge at which the counters wrap from the last pixel of the last line back to the origin.
- R4: With `pix_ce` held high a line lasts hsync+hbp+width+hfp cycles and `lcd_hsync` is active for the first hsync cycles. Register 0x8 bits 15:0 hold hsync-1. Register 0xA holds hfp-1 in bits 15:0 and hbp-1 in bits 31:16. Register 0xB bits 15:0 hold width-1. While the pixel clock stage is off the counters hold at the origin.
- R5: A frame lasts vsync+vbp+height+vfp lines and `lcd_vsync` is active for the first vsync lines. Register 0x8 bits 31:16 hold vsync-1. Register 0x9 holds vfp-1 in bits 15:0 and vbp, with no offset, in bits 31:16. Register 0xB bits 31:16 hold height-1.
- R6: `lcd_de` is high only while both counters are in their active segment and the display stage status is on, giving width×height cycles per frame.
- R7: In register 0xC, bit 0 makes `lcd_hsync` active-low and bit 1 makes `lcd_vsync` active-low. The idle level is the inverse of the active level.
- R8: A start-of-frame pending flag is set at every counter wrap. `sof_irq` is high exactly when the flag and the mask are both set. Writing bit 0 to 0x3 opens the mask, and writing bit 0 to 0x4 closes it.
- R9: A read of 0x5 returns the pending flag in bit 0 and clears it. If a wrap falls in the same cycle as that read, the flag stays set.
- R10: While the sync status is off, `lcd_hsync` and `lcd_vsync` sit at their idle level. While the display status is off, `lcd_de` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Pixel step enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data enable |
| sof_irq | output | 1 | Start-of-frame interrupt |

## Verification
Two events can fall in the same cycle: the read-to-clear of the pending flag and the counter wrap that sets it again. The bench freezes the counters by holding `pix_ce` low and steps them one pixel at a time onto the last position of the frame. It then raises `pix_ce` and `bus_rd` at address 0x5 together. That read must return the cleared value 0, `sof_irq` must stay high, and a second read must return 1, which shows that the set won. The same stepping idea is used to judge stage switching: a status read just after a sync or display request must still show the old value until the frame wraps.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int FIELD_W = 16;
  localparam int DATA_W  = 2 * FIELD_W;
  localparam int ADDR_W  = 4;
  localparam int NUM_STG = 3;
  localparam int STG_PCLK = 0;
  localparam int STG_SYNC = 1;
  localparam int STG_DISP = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_STAGE_SET  = 4'h0,
    A_STAGE_CLR  = 4'h1,
    A_STAGE_STAT = 4'h2,
    A_IRQ_OPEN   = 4'h3,
    A_IRQ_CLOSE  = 4'h4,
    A_IRQ_PEND   = 4'h5,
    A_IRQ_MASKRD = 4'h6,
    A_TIM_SYNC   = 4'h8,
    A_TIM_VPORCH = 4'h9,
    A_TIM_HPORCH = 4'hA,
    A_TIM_ACTIVE = 4'hB,
    A_POLARITY   = 4'hC
  } reg_addr_e;

  typedef struct packed {
    logic [FIELD_W-1:0] hsw_m1;
    logic [FIELD_W-1:0] vsw_m1;
    logic [FIELD_W-1:0] hbp_m1;
    logic [FIELD_W-1:0] hfp_m1;
    logic [FIELD_W-1:0] vbp;
    logic [FIELD_W-1:0] vfp_m1;
    logic [FIELD_W-1:0] wid_m1;
    logic [FIELD_W-1:0] hgt_m1;
  } timing_regs_t;
endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] sync_len,
  input  logic [CNT_W-1:0] bp_len,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] fp_len,
  output logic             last,
  output logic             in_sync,
  output logic             in_act
);
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] act_beg;
  logic [CNT_W-1:0] act_end;
  logic [CNT_W-1:0] total;

  assign act_beg = sync_len + bp_len;
  assign act_end = act_beg + act_len;
  assign total   = act_end + fp_len;

  assign last    = (pos == total - CNT_W'(1));
  assign in_sync = (pos < sync_len);
  assign in_act  = (pos >= act_beg) && (pos < act_end);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos <= '0;
    end else if (adv) begin
      pos <= last ? '0 : pos + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               frame_tick,
  output timing_regs_t       tim,
  output logic [1:0]         pol,
  output logic [NUM_STG-1:0] stage_stat,
  output logic               sof_mask,
  output logic               sof_pend,
  output logic [DATA_W-1:0]  bus_rdata
);
  logic [NUM_STG-1:0] req_q;
  logic [NUM_STG-1:0] req_d;
  logic               pend_rd;

  assign pend_rd = bus_rd && (bus_addr == A_IRQ_PEND);

  always_comb begin
    req_d = req_q;
    if (bus_wr && bus_addr == A_STAGE_SET) req_d = req_q | bus_wdata[NUM_STG-1:0];
    if (bus_wr && bus_addr == A_STAGE_CLR) req_d = req_q & ~bus_wdata[NUM_STG-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= '0;
      stage_stat <= '0;
      tim        <= '0;
      pol        <= '0;
      sof_mask   <= 1'b0;
      sof_pend   <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      req_q <= req_d;
      stage_stat[STG_PCLK] <= req_d[STG_PCLK];
      if (frame_tick) begin
        stage_stat[STG_SYNC] <= req_d[STG_SYNC];
        stage_stat[STG_DISP] <= req_d[STG_DISP];
      end
      sof_pend <= (sof_pend && !pend_rd) || frame_tick;
      if (bus_wr) begin
        case (bus_addr)
          A_IRQ_OPEN:   if (bus_wdata[0]) sof_mask <= 1'b1;
          A_IRQ_CLOSE:  if (bus_wdata[0]) sof_mask <= 1'b0;
          A_TIM_SYNC:   {tim.vsw_m1, tim.hsw_m1} <= bus_wdata;
          A_TIM_VPORCH: {tim.vbp, tim.vfp_m1}    <= bus_wdata;
          A_TIM_HPORCH: {tim.hbp_m1, tim.hfp_m1} <= bus_wdata;
          A_TIM_ACTIVE: {tim.hgt_m1, tim.wid_m1} <= bus_wdata;
          A_POLARITY:   pol <= bus_wdata[1:0];
          default: ;
        endcase
      end
      if (bus_rd) begin
        case (bus_addr)
          A_STAGE_STAT: bus_rdata <= DATA_W'(stage_stat);
          A_IRQ_PEND:   bus_rdata <= DATA_W'(sof_pend);
          A_IRQ_MASKRD: bus_rdata <= DATA_W'(sof_mask);
          A_TIM_SYNC:   bus_rdata <= {tim.vsw_m1, tim.hsw_m1};
          A_TIM_VPORCH: bus_rdata <= {tim.vbp, tim.vfp_m1};
          A_TIM_HPORCH: bus_rdata <= {tim.hbp_m1, tim.hfp_m1};
          A_TIM_ACTIVE: bus_rdata <= {tim.hgt_m1, tim.wid_m1};
          A_POLARITY:   bus_rdata <= DATA_W'(pol);
          default:      bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_ce,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              lcd_hsync,
  output logic              lcd_vsync,
  output logic              lcd_de,
  output logic              sof_irq
);
  localparam int CNT_W  = FIELD_W + 3;
  localparam int N_AXIS = 2;

  timing_regs_t                         tim;
  logic [1:0]                           pol;
  logic [NUM_STG-1:0]                   stage_stat;
  logic                                 sof_mask;
  logic                                 sof_pend;
  logic                                 frame_tick;
  logic                                 run;
  logic [N_AXIS-1:0][3:0][CNT_W-1:0]    seg;
  logic [N_AXIS-1:0]                    adv;
  logic [N_AXIS-1:0]                    last;
  logic [N_AXIS-1:0]                    in_sync;
  logic [N_AXIS-1:0]                    in_act;

  lcd_tg_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .frame_tick (frame_tick),
    .tim        (tim),
    .pol        (pol),
    .stage_stat (stage_stat),
    .sof_mask   (sof_mask),
    .sof_pend   (sof_pend),
    .bus_rdata  (bus_rdata)
  );

  assign run = stage_stat[STG_PCLK];

  assign seg[0][0] = CNT_W'(tim.hsw_m1) + CNT_W'(1);
  assign seg[0][1] = CNT_W'(tim.hbp_m1) + CNT_W'(1);
  assign seg[0][2] = CNT_W'(tim.wid_m1) + CNT_W'(1);
  assign seg[0][3] = CNT_W'(tim.hfp_m1) + CNT_W'(1);
  assign seg[1][0] = CNT_W'(tim.vsw_m1) + CNT_W'(1);
  assign seg[1][1] = CNT_W'(tim.vbp);
  assign seg[1][2] = CNT_W'(tim.hgt_m1) + CNT_W'(1);
  assign seg[1][3] = CNT_W'(tim.vfp_m1) + CNT_W'(1);

  assign adv[0]     = run && pix_ce;
  assign adv[1]     = adv[0] && last[0];
  assign frame_tick = adv[1] && last[1];

  for (genvar ax = 0; ax < N_AXIS; ax++) begin : g_axis
    lcd_tg_axis #(.CNT_W(CNT_W)) u_axis (
      .clk      (clk),
      .rst      (rst),
      .clr      (!run),
      .adv      (adv[ax]),
      .sync_len (seg[ax][0]),
      .bp_len   (seg[ax][1]),
      .act_len  (seg[ax][2]),
      .fp_len   (seg[ax][3]),
      .last     (last[ax]),
      .in_sync  (in_sync[ax]),
      .in_act   (in_act[ax])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_hsync <= 1'b0;
      lcd_vsync <= 1'b0;
      lcd_de    <= 1'b0;
    end else begin
      lcd_hsync <= (stage_stat[STG_SYNC] && in_sync[0]) ^ pol[0];
      lcd_vsync <= (stage_stat[STG_SYNC] && in_sync[1]) ^ pol[1];
      lcd_de    <= stage_stat[STG_DISP] && in_act[0] && in_act[1];
    end
  end

  assign sof_irq = sof_pend && sof_mask;
endmodule

// File: rtl/lcd_tg_checker.sv
module lcd_tg_checker (
  input logic       clk,
  input logic       rst,
  input logic       frame_tick,
  input logic [2:0] stage_stat,
  input logic [1:0] pol,
  input logic       sof_pend,
  input logic       sof_mask,
  input logic       bus_wr,
  input logic [3:0] bus_addr,
  input logic       wdata0,
  input logic       hsync,
  input logic       de,
  input logic       irq
);
  AST_PCLK_FOLLOWS_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'h0 && wdata0) |=> stage_stat[0]); // R2

  AST_STAGE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (stage_stat[2:1] != $past(stage_stat[2:1])) |-> $past(frame_tick)); // R3

  AST_DE_NEEDS_DISP: assert property (@(posedge clk) disable iff (rst)
    de |-> $past(stage_stat[2])); // R6

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(frame_tick) || $rose(sof_mask))); // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> sof_pend); // R9

  AST_HS_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !$past(stage_stat[1]) |-> (hsync == $past(pol[0]))); // R10
endmodule

bind lcd_timing_gen lcd_tg_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_tick (frame_tick),
  .stage_stat (stage_stat),
  .pol        (pol),
  .sof_pend   (sof_pend),
  .sof_mask   (sof_mask),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .wdata0     (bus_wdata[0]),
  .hsync      (lcd_hsync),
  .de         (lcd_de),
  .irq        (sof_irq)
);

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_ce = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lcd_hsync, lcd_vsync, lcd_de, sof_irq;
  logic [1:0]  pol_tb = 2'b00;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  // frame geometry: hsync 2, hbp 3, width 4, hfp 1 ; vsync 1, vbp 2, height 3, vfp 1
  localparam int HTOT = 10;
  localparam int VTOT = 7;
  localparam int FRAME = HTOT * VTOT;

  always #10 clk = ~clk;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .sof_irq(sof_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic act_lvl(input int sel);
    case (sel)
      0: return lcd_hsync ^ pol_tb[0];
      1: return lcd_vsync ^ pol_tb[1];
      default: return lcd_de;
    endcase
  endfunction

  task automatic wait_rise(input int sel, output int n);
    logic prev, cur;
    prev = act_lvl(sel);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      cur = act_lvl(sel);
      if (!prev && cur) break;
      prev = cur;
    end while (n < 500);
  endtask

  task automatic high_len(input int sel, output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (act_lvl(sel) && n < 500) n++;
      else break;
    end
  endtask

  task automatic poll_stat(input int bitn, input logic want, output int n);
    logic [31:0] d;
    n = 0;
    do begin
      rd(4'h2, d);
      n++;
    end while (d[bitn] != want && n < 200);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check(lcd_hsync == 0 && lcd_vsync == 0 && lcd_de == 0, "R1 sync/de low", lcd_hsync, 0);
    check(sof_irq == 0, "R1 irq low", sof_irq, 0);
    rd(4'h2, d);
    check(d == 0, "R1 status", d, 0);
    rd(4'h6, d);
    check(d == 0, "R1 mask closed", d, 0);
  endtask

  task automatic t_bringup;
    logic [31:0] d;
    int n;
    wr(4'h8, 32'h0000_0001);
    wr(4'h9, 32'h0002_0000);
    wr(4'hA, 32'h0002_0000);
    wr(4'hB, 32'h0002_0003);
    wr(4'h0, 32'h1);
    rd(4'h2, d);
    check(d[2:0] == 3'b001, "R2 pixel clock status", d[2:0], 1);
    wr(4'h0, 32'h2);
    rd(4'h2, d);
    check(d[1] == 1'b0, "R3 sync waits for wrap", d[1], 0);
    poll_stat(1, 1'b1, n);
    check(n > 1 && n <= FRAME, "R3 sync on within one frame", n, FRAME);
    wr(4'h0, 32'h4);
    rd(4'h2, d);
    check(d[2] == 1'b0, "R3 display waits for wrap", d[2], 0);
    poll_stat(2, 1'b1, n);
    check(n > 1 && n <= FRAME, "R3 display on within one frame", n, FRAME);
  endtask

  task automatic t_hline;
    int n;
    wait_rise(0, n);
    wait_rise(0, n);
    check(n == HTOT, "R4 line period", n, HTOT);
    high_len(0, n);
    check(n == 2, "R4 hsync width", n, 2);
    wait_rise(2, n);
    high_len(2, n);
    check(n == 4, "R4 active width", n, 4);
    wait_rise(0, n);
    check(n == 1, "R4 front porch", n, 1);
  endtask

  task automatic t_vframe;
    int n, cnt;
    wait_rise(1, n);
    wait_rise(1, n);
    check(n == FRAME, "R5 frame period", n, FRAME);
    high_len(1, n);
    check(n == HTOT, "R5 vsync width", n, HTOT);
    wait_rise(1, n);
    wait_rise(2, n);
    check(n == 35, "R5 direct back porch offset", n, 35);
    wait_rise(1, n);
    cnt = 0;
    for (int i = 0; i < FRAME; i++) begin
      if (lcd_de) cnt++;
      @(negedge clk);
    end
    check(cnt == 12, "R6 de count per frame", cnt, 12);
  endtask

  task automatic t_polarity;
    int n;
    wr(4'hC, 32'h3);
    pol_tb = 2'b11;
    repeat (3) @(negedge clk);
    wait_rise(0, n);
    check(lcd_hsync == 1'b0, "R7 hsync active low", lcd_hsync, 0);
    high_len(0, n);
    check(n == 2, "R7 inverted hsync width", n, 2);
    check(lcd_hsync == 1'b1, "R7 hsync idle high", lcd_hsync, 1);
    wait_rise(1, n);
    check(lcd_vsync == 1'b0, "R7 vsync active low", lcd_vsync, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    int n;
    wr(4'h3, 32'h1);
    rd(4'h5, d);
    n = 0;
    while (!sof_irq && n < 200) begin @(negedge clk); n++; end
    check(sof_irq && n <= FRAME, "R8 irq at frame start", n, FRAME);
    rd(4'h5, d);
    check(d[0] == 1'b1, "R9 pending read", d[0], 1);
    check(sof_irq == 1'b0, "R9 irq drops after read", sof_irq, 0);
    rd(4'h5, d);
    check(d[0] == 1'b0, "R9 pending cleared", d[0], 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    bit seen = 0;
    wr(4'h4, 32'h1);
    rd(4'h5, d);
    for (int i = 0; i < FRAME + 10; i++) begin
      @(negedge clk);
      if (sof_irq) seen = 1;
    end
    check(!seen, "R8 masked irq stays low", seen, 0);
    rd(4'h5, d);
    check(d[0] == 1'b1, "R8 pending set while masked", d[0], 1);
    wr(4'h3, 32'h1);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    int n;
    rd(4'h5, d);
    n = 0;
    while (!sof_irq && n < 200) begin @(negedge clk); n++; end
    pix_ce = 1'b0;
    rd(4'h5, d);
    pix_ce = 1'b1;
    repeat (FRAME - 1) @(negedge clk);
    pix_ce = 1'b0;
    @(negedge clk);
    check(sof_irq == 1'b0, "R9 cleared before wrap", sof_irq, 0);
    pix_ce = 1'b1;
    rd(4'h5, d);
    pix_ce = 1'b0;
    check(d[0] == 1'b0, "R9 read during wrap returns old", d[0], 0);
    check(sof_irq == 1'b1, "R9 set wins over clear", sof_irq, 1);
    rd(4'h5, d);
    check(d[0] == 1'b1, "R9 pending kept", d[0], 1);
    pix_ce = 1'b1;
  endtask

  task automatic t_shutdown;
    logic [31:0] d;
    int n;
    bit bad;
    wr(4'h1, 32'h4);
    poll_stat(2, 1'b0, n);
    check(n <= FRAME, "R3 display off at wrap", n, FRAME);
    bad = 0;
    for (int i = 0; i < FRAME + 5; i++) begin
      @(negedge clk);
      if (lcd_de) bad = 1;
    end
    check(!bad, "R10 de low with display off", bad, 0);
    wr(4'h1, 32'h2);
    rd(4'h2, d);
    check(d[1] == 1'b1, "R3 sync holds until wrap", d[1], 1);
    poll_stat(1, 1'b0, n);
    check(n <= FRAME, "R3 sync off at wrap", n, FRAME);
    bad = 0;
    for (int i = 0; i < FRAME + 5; i++) begin
      @(negedge clk);
      if (lcd_hsync != pol_tb[0] || lcd_vsync != pol_tb[1]) bad = 1;
    end
    check(!bad, "R10 syncs idle with sync off", bad, 0);
    wr(4'h1, 32'h1);
    rd(4'h2, d);
    check(d[2:0] == 3'b000, "R2 pixel clock off", d[2:0], 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_bringup;
    t_hline;
    t_vframe;
    t_polarity;
    t_irq;
    t_mask;
    t_collide;
    t_shutdown;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule